// File: doc/BRIEF.md
# Fuse ID Word Readout Controller

This block fronts a small one-time-programmable identification array of 64 words of 32 bits each. Software fetches one fuse word by writing a control register with a word index, a key byte and a fetch bit. While the fetch runs, the fetch bit reads back as 1. Software polls that bit until it drops, takes the word from a result register, and then writes zero to the control register to end the exchange.

The block also decodes a read-only mirror window of the whole array. After reset every mirror entry reads zero, so a mirror entry is stale until a register fetch of that same word completes. The completing fetch copies the word into its mirror entry.

Access goes over a simple single-cycle 32-bit register bus. The fuse array is modelled inside the block. Its contents are computed from the word index and it answers after a fixed number of cycles.

Top module: `efuse_rdout_ctrl`

## Requirements
- R1: Every bus request (`req_valid` high at a rising edge) gets `rsp_ack` high for exactly the following cycle, and read data is valid in that same cycle. When `rsp_ack` is low, or the acknowledged request was a write, `rsp_rdata` is 0. Bus addresses are byte addresses and bits 1:0 are ignored.
- R2: The control register sits at byte offset 0x40 and reads back as follows. Bits 24:16 hold the stored word index. Bits 15:8 hold the stored key. Bit 1 is the busy/fetch bit. All other bits are 0. It is 0 after reset.
- R3: A write to the control register while idle stores the index and the key. It starts a fetch only when bit 1 is set and bits 15:8 equal 0xAC. With any other key, or with bit 1 clear, bit 1 reads back 0.
- R4: A write to the control register while a fetch is busy is ignored entirely. The stored index and key keep their values, and the running fetch completes with its original word.
- R5: Bit 1 reads 1 in the 8 consecutive cycles after the accepting edge and reads 0 in the 9th. The result and the mirror are updated on that same edge.
- R6: The fuse word at index i (0 to 63) is 0x1F2E3D4C XOR (i * 0x01000193), truncated to 32 bits. An index above 63 yields 0 and still completes after the normal latency.
- R7: The result register at byte offset 0x60 returns the last fetched word. It is 0 after reset, and writes to it have no effect.
- R8: Mirror word i is at byte offset 0x200 + 4*i. It reads 0 after reset until a fetch of index i completes, and then reads that fetched word. A fetch with an index above 63 changes no mirror entry.
- R9: Writes into the mirror window and to unmapped offsets have no effect. Reads from unmapped offsets return 0.
- R10: Writing 0 to the control register while idle clears the stored index and key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with acknowledge |

## Verification
Each bus access is acknowledged one cycle after its request edge, so the bench drives one request per edge. It samples acknowledge and data at the falling edge that follows.

A fetch accepted at edge E0 keeps bit 1 set for reads sampled at edges E1 to E8 and clears it for a read at E9. The bench therefore polls the control register back to back from the edge right after the command and requires exactly 8 busy reads. The result register and the mirror entry are read only after the poll has seen bit 1 at 0, which is the earliest edge at which both hold the new word.

// File: rtl/efuse_pkg.sv
package efuse_pkg;
  localparam int ADDR_W   = 10;
  localparam int IDX_W    = 9;
  localparam int CTRL_OFS = 'h040;
  localparam int DATA_OFS = 'h060;
  localparam int MIR_BASE = 'h200;
  localparam logic [7:0] LOCK_KEY = 8'hAC;
  localparam logic [31:0] FUSE_MULT = 32'h0100_0193;

  // control register bit positions
  localparam int IDX_LSB  = 16;
  localparam int KEY_LSB  = 8;
  localparam int FETCH_BIT = 1;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [7:0]       key;
  } ctrl_t;
endpackage

// File: rtl/efuse_array.sv
module efuse_array
  import efuse_pkg::*;
#(
  parameter int          WORDS   = 64,
  parameter int          LATENCY = 8,
  parameter logic [31:0] SEED    = 32'h1F2E_3D4C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] idx_in,
  output logic             fin,
  output logic [31:0]      word
);
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic             active;
  logic [CW-1:0]    cnt;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      idx_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CW'(LATENCY - 1);
      idx_q  <= idx_in;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign fin  = active && (cnt == '0);
  assign word = (idx_q < IDX_W'(WORDS)) ? (SEED ^ (32'(idx_q) * FUSE_MULT)) : 32'h0;
endmodule

// File: rtl/efuse_cmd.sv
module efuse_cmd
  import efuse_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  input  logic        fin,
  output logic        start,
  output logic        busy,
  output ctrl_t       ctrl
);
  logic accept;
  logic unused_wbits;

  assign accept = wr_ctrl && !busy;
  assign start  = accept && wdata[FETCH_BIT] && (wdata[KEY_LSB +: 8] == LOCK_KEY);
  assign unused_wbits = ^{wdata[31:IDX_LSB+IDX_W], wdata[KEY_LSB-1:FETCH_BIT+1], wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      busy <= 1'b0;
    end else if (accept) begin
      ctrl.idx <= wdata[IDX_LSB +: IDX_W];
      ctrl.key <= wdata[KEY_LSB +: 8];
      busy     <= start;
    end else if (fin) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/efuse_mirror.sv
module efuse_mirror #(
  parameter int WORDS = 64,
  localparam int MW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [MW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [MW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/efuse_rdout_ctrl.sv
module efuse_rdout_ctrl
  import efuse_pkg::*;
#(
  parameter int          WORDS   = 64,
  parameter int          LATENCY = 8,
  parameter logic [31:0] SEED    = 32'h1F2E_3D4C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ack,
  output logic [31:0]       rsp_rdata
);
  localparam int MW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int MIR_LIMIT = MIR_BASE + 4 * WORDS;

  logic              hit_ctrl, hit_data, hit_mir;
  logic [ADDR_W-1:0] mir_off;
  logic              start, busy, fin, mir_we;
  logic [31:0]       word, mir_rd, data_q, rd_mux;
  ctrl_t             ctrl;
  logic [IDX_W-1:0]  ctrl_idx;
  logic              unused_abits;

  assign hit_ctrl = req_addr[ADDR_W-1:2] == CTRL_OFS[ADDR_W-1:2];
  assign hit_data = req_addr[ADDR_W-1:2] == DATA_OFS[ADDR_W-1:2];
  assign hit_mir  = ({1'b0, req_addr} >= (ADDR_W+1)'(MIR_BASE)) &&
                    ({1'b0, req_addr} <  (ADDR_W+1)'(MIR_LIMIT));
  assign mir_off  = req_addr - ADDR_W'(MIR_BASE);
  assign unused_abits = ^{req_addr[1:0], mir_off};

  efuse_cmd u_cmd (
    .clk(clk), .rst(rst),
    .wr_ctrl(req_valid && req_write && hit_ctrl),
    .wdata(req_wdata), .fin(fin),
    .start(start), .busy(busy), .ctrl(ctrl)
  );

  assign ctrl_idx = ctrl.idx;

  efuse_array #(.WORDS(WORDS), .LATENCY(LATENCY), .SEED(SEED)) u_array (
    .clk(clk), .rst(rst), .start(start),
    .idx_in(req_wdata[IDX_LSB +: IDX_W]),
    .fin(fin), .word(word)
  );

  assign mir_we = fin && (ctrl_idx < IDX_W'(WORDS));

  efuse_mirror #(.WORDS(WORDS)) u_mirror (
    .clk(clk), .rst(rst), .we(mir_we),
    .waddr(ctrl_idx[MW-1:0]), .wdata(word),
    .raddr(mir_off[2 +: MW]), .rdata(mir_rd)
  );

  always_ff @(posedge clk) begin
    if (rst)      data_q <= '0;
    else if (fin) data_q <= word;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[IDX_LSB +: IDX_W] = ctrl.idx;
      rd_mux[KEY_LSB +: 8]     = ctrl.key;
      rd_mux[FETCH_BIT]        = busy;
    end else if (hit_data) begin
      rd_mux = data_q;
    end else if (hit_mir) begin
      rd_mux = mir_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ack   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ack   <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : 32'h0;
    end
  end
endmodule

// File: rtl/efuse_rdout_chk.sv
module efuse_rdout_chk #(
  parameter int LATENCY = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [7:0]  req_word,
  input logic [7:0]  req_key,
  input logic        rsp_ack,
  input logic [31:0] rsp_rdata,
  input logic        busy,
  input logic        fin,
  input logic        mir_we,
  input logic [8:0]  ctrl_idx
);
  logic        ctrl_wr;
  logic [15:0] lat_cnt;

  assign ctrl_wr = req_valid && req_write && (req_word == 8'h10);

  always_ff @(posedge clk) begin
    if (rst) lat_cnt <= '0;
    else     lat_cnt <= busy ? lat_cnt + 1'b1 : 16'd0;
  end

  p_ack_next_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_ack);
  p_no_spurious_ack_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_ack);
  p_idle_data_r1: assert property (@(posedge clk) disable iff (rst)
    !rsp_ack |-> rsp_rdata == 32'h0);
  p_bad_key_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !busy && req_key != 8'hAC) |=> !busy);
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && busy && !fin) |=> $stable(ctrl_idx) && busy);
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> lat_cnt == 16'(LATENCY));
  p_busy_window_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> lat_cnt < 16'(LATENCY));
  p_mirror_source_r8: assert property (@(posedge clk) disable iff (rst)
    mir_we |-> fin && busy);
endmodule

bind efuse_rdout_ctrl efuse_rdout_chk #(.LATENCY(LATENCY)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_word(req_addr[9:2]), .req_key(req_wdata[15:8]),
  .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
  .busy(busy), .fin(fin), .mir_we(mir_we), .ctrl_idx(ctrl_idx)
);

// File: tb/test_efuse_rdout_ctrl.sv
`timescale 1ns/1ps
module test_efuse_rdout_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [9:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_ack;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  efuse_rdout_ctrl i_efuse_rdout_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] fuse_word(int i);
    logic [31:0] p;
    p = 32'(i) * 32'h0100_0193;
    return (i >= 0 && i < 64) ? (32'h1F2E_3D4C ^ p) : 32'h0;
  endfunction

  function automatic logic [31:0] ctrl_val(int idx, logic [7:0] key, logic go);
    return (32'(idx & 9'h1FF) << 16) | (32'(key) << 8) | (32'(go) << 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [9:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 ack", 32'(rsp_ack), 32'd1);
    rd = rsp_rdata;
    if (wr) check("R1 write data zero", rd, 32'h0);
  endtask

  task automatic poll(output int n);
    logic [31:0] rd;
    n = 0;
    do begin
      bus(1'b0, 10'h040, 32'h0, rd);
      if (rd[1]) n++;
    end while (rd[1] && n < 40);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 idle ack", 32'(rsp_ack), 32'd0);
    check("R1 idle data", rsp_rdata, 32'h0);
    bus(1'b0, 10'h040, 0, rd); check("R2 ctrl reset", rd, 32'h0);
    bus(1'b0, 10'h060, 0, rd); check("R7 data reset", rd, 32'h0);
    @(negedge clk);
    check("R1 no ack without request", 32'(rsp_ack), 32'd0);

    // full sweep of all fuse words
    for (int i = 0; i < 64; i++) begin
      bus(1'b0, 10'(10'h200 + 4*i), 0, rd); check("R8 mirror stale", rd, 32'h0);
      bus(1'b1, 10'h040, ctrl_val(i, 8'hAC, 1'b1), rd);
      bus(1'b0, 10'h040, 0, rd); check("R2 ctrl busy readback", rd, ctrl_val(i, 8'hAC, 1'b1));
      poll(n); check("R5 busy cycles", n, 32'd7);
      bus(1'b0, 10'h060, 0, rd); check("R6 fuse word", rd, fuse_word(i));
      bus(1'b0, 10'(10'h200 + 4*i), 0, rd); check("R8 mirror filled", rd, fuse_word(i));
      if (i < 63) begin
        bus(1'b0, 10'(10'h204 + 4*i), 0, rd); check("R8 next still stale", rd, 32'h0);
      end
      bus(1'b1, 10'h040, 32'h0, rd);
      bus(1'b0, 10'h040, 0, rd); check("R10 release", rd, 32'h0);
    end

    // exact latency from accepting edge
    bus(1'b1, 10'h040, ctrl_val(3, 8'hAC, 1'b1), rd);
    poll(n); check("R5 exact busy count", n, 32'd8);

    // key sweep
    for (int k = 0; k < 256; k++) begin
      if (k != 'hAC) begin
        bus(1'b1, 10'h040, ctrl_val(5, 8'(k), 1'b1), rd);
        bus(1'b0, 10'h040, 0, rd); check("R3 wrong key", rd, ctrl_val(5, 8'(k), 1'b0));
      end
    end
    bus(1'b1, 10'h040, ctrl_val(7, 8'hAC, 1'b0), rd);
    bus(1'b0, 10'h040, 0, rd); check("R3 key without fetch bit", rd, ctrl_val(7, 8'hAC, 1'b0));

    // write while busy
    bus(1'b1, 10'h040, ctrl_val(10, 8'hAC, 1'b1), rd);
    bus(1'b1, 10'h040, ctrl_val(20, 8'hAC, 1'b1), rd);
    bus(1'b1, 10'h040, 32'h0, rd);
    bus(1'b0, 10'h040, 0, rd); check("R4 ignored while busy", rd, ctrl_val(10, 8'hAC, 1'b1));
    poll(n); check("R4 busy count kept", n, 32'd5);
    bus(1'b0, 10'h060, 0, rd); check("R4 original word", rd, fuse_word(10));

    // out of range index
    bus(1'b1, 10'h040, ctrl_val(100, 8'hAC, 1'b1), rd);
    poll(n); check("R6 high index latency", n, 32'd8);
    bus(1'b0, 10'h060, 0, rd); check("R6 high index zero", rd, 32'h0);
    bus(1'b0, 10'h290, 0, rd); check("R8 high index no mirror write", rd, fuse_word(36));
    bus(1'b0, 10'h200, 0, rd); check("R8 entry 0 kept", rd, fuse_word(0));

    // ignored writes and unmapped reads
    bus(1'b1, 10'h060, 32'hDEAD_BEEF, rd);
    bus(1'b0, 10'h060, 0, rd); check("R7 data write ignored", rd, 32'h0);
    bus(1'b1, 10'h204, 32'hFFFF_FFFF, rd);
    bus(1'b0, 10'h204, 0, rd); check("R9 mirror write ignored", rd, fuse_word(1));
    bus(1'b1, 10'h040, 32'h0, rd);
    bus(1'b1, 10'h044, ctrl_val(9, 8'hAC, 1'b1), rd);
    bus(1'b0, 10'h040, 0, rd); check("R9 unmapped write ignored", rd, 32'h0);
    bus(1'b0, 10'h000, 0, rd); check("R9 unmapped 0x000", rd, 32'h0);
    bus(1'b0, 10'h044, 0, rd); check("R9 unmapped 0x044", rd, 32'h0);
    bus(1'b0, 10'h1FC, 0, rd); check("R9 unmapped 0x1FC", rd, 32'h0);
    bus(1'b0, 10'h300, 0, rd); check("R9 unmapped 0x300", rd, 32'h0);
    bus(1'b0, 10'h3FC, 0, rd); check("R9 unmapped 0x3FC", rd, 32'h0);
    bus(1'b0, 10'h2FF, 0, rd); check("R1 low bits ignored", rd, fuse_word(63));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule